// File: doc/BRIEF.md
# SDRAM Read Latency and Byte-Mask Pipeline

This block is the read return path on the device side of a 32-bit synchronous DRAM model. Each clock, the array side may present one read word together with a marker for the first word of a burst. The block holds each accepted word for a number of clocks set by the latency code from the mode register, then drives it out with one output enable per byte lane. Byte masks that arrive during a read blank their lanes two clocks later, whatever latency is set. A burst-stop or precharge command cuts the current burst short, and the bus floats exactly one latency period after that command.

A registered clock enable stops every stage. When the enable is sampled low, the next edge does not move the pipeline, the mask stages or the burst state, and the outputs hold. The block also watches the latency code. It raises a one-cycle error flag when the code holds a reserved value, or when the code changes while read data is still in flight.

Top module: `rd_lat_mask_pipe`

## Requirements
- R1: While reset is applied, `dq_oe` is 0, `dq_out` is 0 and `lat_err` is 0.
- R2: With `lat_code` = 3'b010 (two clocks), a word accepted at edge n is on `dq_out` with all four lane enables high from just after edge n+1 until edge n+2, so it is valid at edge n+2.
- R3: With `lat_code` = 3'b011 (three clocks), a word accepted at edge n is driven from just after edge n+2 until edge n+3.
- R4: A word is accepted when `beat_vld` is high and either `rd_start` is high or the burst is still live. A burst stays live while consecutive edges carry `beat_vld`. A `beat_vld` with no live burst and no `rd_start` is ignored, and its slot keeps every enable low.
- R5: When `byte_mask` bit b is sampled high at edge k, lane b of the word driven between edges k+1 and k+2 has its enable low and its data bits zero. This holds under both latencies. Bit 3 is lane 31:24, bit 2 is 23:16, bit 1 is 15:8 and bit 0 is 7:0.
- R6: A mask acts only on the one word that matches its sampling edge. The next word is driven on every lane.
- R7: A `burst_stop` or `pre_cmd` at edge k discards any word presented at edge k and every later word of that burst. Words accepted before edge k still come out, and no lane is driven in the slot that is valid at edge k+CL.
- R8: When `clk_en` is sampled low at edge k, each following edge up to and including the first one after `clk_en` is sampled high again holds the delay stages, the mask stages and the burst state. `dq_out` and `dq_oe` keep their values, and words or masks presented at those edges are ignored.
- R9: `lat_err` is high for exactly the cycle after an edge at which `lat_code` differs from its value at the previous edge while a word is in flight or a burst is live.
- R10: `lat_err` is high after every edge at which `lat_code` holds a reserved value, meaning anything other than 3'b010 or 3'b011.
- R11: A change between legal codes while nothing is in flight leaves `lat_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; a low sample freezes the following edge |
| lat_code | input | 3 | Latency code from the mode register |
| rd_start | input | 1 | First word of a read burst |
| beat_vld | input | 1 | A read word is present on `beat_data` |
| beat_data | input | 32 | Read word from the array |
| byte_mask | input | 4 | Per-lane read mask, fixed two-clock effect |
| burst_stop | input | 1 | Burst-stop command |
| pre_cmd | input | 1 | Precharge command aimed at the reading bank |
| dq_out | output | 32 | Output data, zero on disabled lanes |
| dq_oe | output | 4 | Per-lane output enable (low means high impedance) |
| lat_err | output | 1 | One-cycle latency-code error flag |

## Verification
The assertions assume that the latency code changes only between bursts, and that `rd_start` is never high together with a stop or precharge on the same edge. The freeze check also assumes the code is steady across the held edge. The directed tasks keep to these rules: they change the code only after the pipeline has drained, and they give terminate commands only in place of a burst's later words. The one exception is the error task. It breaks the first rule on purpose, and the data compare is switched off until the pipeline has drained again.

// File: rtl/rdlp_pkg.sv
package rdlp_pkg;

  // width of one byte lane on the data bus
  localparam int unsigned LANE_W   = 8;
  // fixed read-mask delay in clocks, independent of the latency code
  localparam int unsigned MASK_LAT = 2;

  // a latency code is usable when it lies inside the supported range
  function automatic logic lat_legal(input int unsigned code,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (code >= lo) && (code <= hi);
  endfunction

endpackage

// File: rtl/rdlp_beat_ctl.sv
module rdlp_beat_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic beat_vld,
  input  logic rd_start,
  input  logic halt,
  output logic accept,
  output logic live
);

  logic live_q;
  logic live_d;

  // burst tracking: a start opens it, a gap or terminate closes it
  always_comb begin
    live_d = live_q;
    if (halt) begin
      live_d = 1'b0;
    end else if (rd_start) begin
      live_d = 1'b1;
    end else if (!beat_vld) begin
      live_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else if (adv) begin
      live_q <= live_d;
    end
  end

  assign accept = beat_vld & ~halt & (rd_start | live_q);
  assign live   = live_q;

endmodule

// File: rtl/rdlp_delay_line.sv
module rdlp_delay_line #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      in_vld,
  input  logic [W-1:0]              in_data,
  output logic [DEPTH-1:0]          vld_o,
  output logic [DEPTH-1:0][W-1:0]   data_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic         src_vld;
    logic [W-1:0] src_data;
    logic         v_q;
    logic         v_d;
    logic [W-1:0] d_q;
    logic [W-1:0] d_d;
    logic         d_en;

    if (i == 0) begin : g_head
      assign src_vld  = in_vld;
      assign src_data = in_data;
    end else begin : g_tail
      assign src_vld  = vld_o[i-1];
      assign src_data = data_o[i-1];
    end

    always_comb begin
      v_d  = src_vld;
      d_d  = src_data;
      d_en = adv & src_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (adv) begin
        v_q <= v_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
      end else if (d_en) begin
        d_q <= d_d;
      end
    end

    assign vld_o[i]  = v_q;
    assign data_o[i] = d_q;
  end

endmodule

// File: rtl/rdlp_mask_line.sv
module rdlp_mask_line #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] mask_o
);

  localparam int unsigned STAGES = rdlp_pkg::MASK_LAT;

  logic [STAGES-1:0][LANES-1:0] m_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_mstage
    logic [LANES-1:0] m_d;
    logic [LANES-1:0] m_r;

    if (i == 0) begin : g_head
      assign m_d = mask_i;
    end else begin : g_tail
      assign m_d = m_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_r <= '0;
      end else if (adv) begin
        m_r <= m_d;
      end
    end

    assign m_q[i] = m_r;
  end

  assign mask_o = m_q[STAGES-1];

endmodule

// File: rtl/rdlp_lat_guard.sv
module rdlp_lat_guard #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned MIN_CL = 2,
  parameter int unsigned MAX_CL = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] lat_code,
  input  logic              busy,
  output logic [SEL_W-1:0]  sel,
  output logic              lat_err
);

  logic              legal;
  logic [CODE_W-1:0] eff;
  logic [CODE_W-1:0] code_q;
  logic              err_d;
  logic              err_q;

  always_comb begin
    legal = rdlp_pkg::lat_legal(32'(lat_code), MIN_CL, MAX_CL);
    eff   = legal ? lat_code : CODE_W'(MAX_CL);
    // stage 0 captures the word, so the tap sits one below the latency
    sel   = SEL_W'(eff - 1'b1);
    err_d = !legal || (busy && (lat_code != code_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_W'(MIN_CL);
      err_q  <= 1'b0;
    end else begin
      code_q <= lat_code;
      err_q  <= err_d;
    end
  end

  assign lat_err = err_q;

endmodule

// File: rtl/rd_lat_mask_pipe.sv
module rd_lat_mask_pipe #(
  parameter int unsigned DQ_W   = 32,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned MIN_CL = 2,
  parameter int unsigned MAX_CL = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clk_en,
  input  logic [CODE_W-1:0]                  lat_code,
  input  logic                               rd_start,
  input  logic                               beat_vld,
  input  logic [DQ_W-1:0]                    beat_data,
  input  logic [DQ_W/rdlp_pkg::LANE_W-1:0]   byte_mask,
  input  logic                               burst_stop,
  input  logic                               pre_cmd,
  output logic [DQ_W-1:0]                    dq_out,
  output logic [DQ_W/rdlp_pkg::LANE_W-1:0]   dq_oe,
  output logic                               lat_err
);

  localparam int unsigned LANE_W = rdlp_pkg::LANE_W;
  localparam int unsigned LANES  = DQ_W / LANE_W;
  localparam int unsigned DEPTH  = MAX_CL;
  localparam int unsigned SEL_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // clock enable takes effect one edge after it is sampled
  logic adv;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      adv <= 1'b1;
    end else begin
      adv <= clk_en;
    end
  end

  logic                         halt;
  logic                         accept;
  logic                         live;
  logic [DEPTH-1:0]             st_vld;
  logic [DEPTH-1:0][DQ_W-1:0]   st_data;
  logic [LANES-1:0]             mask_d;
  logic [SEL_W-1:0]             sel;
  logic                         busy;

  assign halt = burst_stop | pre_cmd;
  assign busy = (|st_vld) | live;

  rdlp_beat_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv      (adv),
    .beat_vld (beat_vld),
    .rd_start (rd_start),
    .halt     (halt),
    .accept   (accept),
    .live     (live)
  );

  rdlp_delay_line #(.W(DQ_W), .DEPTH(DEPTH)) u_dly (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv     (adv),
    .in_vld  (accept),
    .in_data (beat_data),
    .vld_o   (st_vld),
    .data_o  (st_data)
  );

  rdlp_mask_line #(.LANES(LANES)) u_msk (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv    (adv),
    .mask_i (byte_mask),
    .mask_o (mask_d)
  );

  rdlp_lat_guard #(
    .CODE_W (CODE_W),
    .MIN_CL (MIN_CL),
    .MAX_CL (MAX_CL),
    .SEL_W  (SEL_W)
  ) u_grd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lat_code (lat_code),
    .busy     (busy),
    .sel      (sel),
    .lat_err  (lat_err)
  );

  logic              tap_vld;
  logic [DQ_W-1:0]   tap_data;

  always_comb begin
    tap_vld  = st_vld[sel];
    tap_data = st_data[sel];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign dq_oe[b] = tap_vld & ~mask_d[b];
    assign dq_out[b*LANE_W +: LANE_W] = dq_oe[b] ? tap_data[b*LANE_W +: LANE_W]
                                                 : {LANE_W{1'b0}};
  end

endmodule

// File: rtl/rdlp_chk.sv
module rdlp_chk #(
  parameter int unsigned DQ_W   = 32,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned MIN_CL = 2,
  parameter int unsigned MAX_CL = 3,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic [CODE_W-1:0] lat_code,
  input logic [LANES-1:0]  byte_mask,
  input logic [DQ_W-1:0]   dq_out,
  input logic [LANES-1:0]  dq_oe,
  input logic              lat_err,
  input logic              adv,
  input logic              halt,
  input logic              st0_vld,
  input logic              busy
);

  // R7: a terminate on a live edge leaves nothing in the capture stage
  a_r7_halt_drops_word: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && halt) |=> !st0_vld);

  // R8: a held edge keeps the bus unchanged
  a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en ##2 $stable(lat_code)) |-> ($stable(dq_oe) && $stable(dq_out)));

  // R5: a sampled mask bit blanks its lane two live edges later
  a_r5_mask_two_clk: assert property (@(posedge clk) disable iff (!rst_n)
    ((adv && (|byte_mask)) ##1 adv) |=> ((dq_oe & $past(byte_mask, 2)) == '0));

  // R9: a code change while busy raises the flag
  a_r9_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (lat_code != $past(lat_code))) |=> lat_err);

  // R10: a reserved code raises the flag
  a_r10_reserved_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(lat_code) < MIN_CL) || (32'(lat_code) > MAX_CL)) |=> lat_err);

  // R11: a steady legal code never raises the flag
  a_r11_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(lat_code) >= MIN_CL) && (32'(lat_code) <= MAX_CL)
      && (lat_code == $past(lat_code))) |=> !lat_err);

endmodule

bind rd_lat_mask_pipe rdlp_chk #(
  .DQ_W   (DQ_W),
  .CODE_W (CODE_W),
  .MIN_CL (MIN_CL),
  .MAX_CL (MAX_CL),
  .LANES  (LANES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .clk_en    (clk_en),
  .lat_code  (lat_code),
  .byte_mask (byte_mask),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .lat_err   (lat_err),
  .adv       (adv),
  .halt      (halt),
  .st0_vld   (st_vld[0]),
  .busy      (busy)
);

// File: tb/rd_lat_mask_pipe_bench.sv
module rd_lat_mask_pipe_bench;

  localparam int SLOTS = 2048;

  logic        clk;
  logic        rst_n;
  logic        clk_en;
  logic [2:0]  lat_code;
  logic        rd_start;
  logic        beat_vld;
  logic [31:0] beat_data;
  logic [3:0]  byte_mask;
  logic        burst_stop;
  logic        pre_cmd;
  logic [31:0] dq_out;
  logic [3:0]  dq_oe;
  logic        lat_err;

  rd_lat_mask_pipe u_rd_lat_mask_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .lat_code   (lat_code),
    .rd_start   (rd_start),
    .beat_vld   (beat_vld),
    .beat_data  (beat_data),
    .byte_mask  (byte_mask),
    .burst_stop (burst_stop),
    .pre_cmd    (pre_cmd),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .lat_err    (lat_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_vec;
  int n_bad;

  // expectation model, indexed by live-edge count
  bit          exp_vld [SLOTS];
  logic [31:0] exp_data[SLOTS];
  logic [3:0]  msk_at  [SLOTS];
  int          pe;
  int          cl;
  bit          adv_next;
  bit          live_m;
  bit          cmp_dq;
  bit          exp_err;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    logic [3:0]  oe_e;
    logic [31:0] d_e;
    oe_e = exp_vld[pe] ? ~msk_at[pe] : 4'h0;
    for (int b = 0; b < 4; b++)
      d_e[b*8 +: 8] = oe_e[b] ? exp_data[pe][b*8 +: 8] : 8'h00;
    if (cmp_dq) begin
      check(tag, "dq_oe", 64'(dq_oe), 64'(oe_e));
      check(tag, "dq_out", 64'(dq_out), 64'(d_e));
    end
    check(tag, "lat_err", 64'(lat_err), 64'(exp_err));
  endtask

  // one clock: drive at the falling edge, model at the rising edge, compare at the next fall
  task automatic step(bit vld, bit st, logic [31:0] d, logic [3:0] m,
                      bit bs, bit pc, bit ce, string tag);
    bit adv_now;
    bit acc;
    beat_vld = vld; rd_start = st; beat_data = d; byte_mask = m;
    burst_stop = bs; pre_cmd = pc; clk_en = ce;
    @(posedge clk);
    adv_now  = adv_next;
    adv_next = ce;
    if (adv_now) begin
      pe++;
      acc = vld && !(bs || pc) && (st || live_m);
      if (bs || pc)     live_m = 1'b0;
      else if (st)      live_m = 1'b1;
      else if (!vld)    live_m = 1'b0;
      if (acc) begin
        exp_vld[pe+cl-1]  = 1'b1;
        exp_data[pe+cl-1] = d;
      end
      if (m != 4'h0) msk_at[pe+1] = m;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 32'h0, 4'h0, 0, 0, 1, tag);
  endtask

  task automatic set_lat(logic [2:0] code);
    lat_code = code;
    cl = int'(code);
  endtask

  // R2: two-clock latency, back-to-back burst of four
  task automatic t_cl2_basic();
    set_lat(3'b010);
    idle(2, "R2");
    step(1, 1, 32'h1122_3344, 4'h0, 0, 0, 1, "R2");
    step(1, 0, 32'h5566_7788, 4'h0, 0, 0, 1, "R2");
    step(1, 0, 32'h99AA_BBCC, 4'h0, 0, 0, 1, "R2");
    step(1, 0, 32'hDDEE_FF00, 4'h0, 0, 0, 1, "R2");
    idle(4, "R2");
  endtask

  // R3: three-clock latency, single word then a burst of two
  task automatic t_cl3_basic();
    set_lat(3'b011);
    idle(2, "R3");
    step(1, 1, 32'hCAFE_0001, 4'h0, 0, 0, 1, "R3");
    idle(1, "R3");
    step(1, 1, 32'h0BAD_F00D, 4'h0, 0, 0, 1, "R3");
    step(1, 0, 32'h1357_9BDF, 4'h0, 0, 0, 1, "R3");
    idle(5, "R3");
  endtask

  // R4: words with no open burst are dropped
  task automatic t_stray();
    step(1, 0, 32'hFFFF_FFFF, 4'h0, 0, 0, 1, "R4");
    step(1, 0, 32'hEEEE_EEEE, 4'h0, 0, 0, 1, "R4");
    idle(4, "R4");
  endtask

  // R5, R6: mask lanes under both latencies, one word only
  task automatic t_mask(logic [2:0] code);
    set_lat(code);
    idle(2, "R5");
    step(1, 1, 32'hA1B2_C3D4, 4'b0001, 0, 0, 1, "R5");
    step(1, 0, 32'hE5F6_0718, 4'b1000, 0, 0, 1, "R5");
    step(1, 0, 32'h293A_4B5C, 4'b0110, 0, 0, 1, "R5");
    step(1, 0, 32'h6D7E_8F90, 4'b0000, 0, 0, 1, "R6");
    step(1, 0, 32'h1020_3040, 4'b0000, 0, 0, 1, "R6");
    idle(5, "R6");
  endtask

  // R7: terminate by burst stop (three clocks) and by precharge (two clocks)
  task automatic t_term();
    set_lat(3'b011);
    idle(2, "R7");
    step(1, 1, 32'h7000_0001, 4'h0, 0, 0, 1, "R7");
    step(1, 0, 32'h7000_0002, 4'h0, 0, 0, 1, "R7");
    step(1, 0, 32'h7000_0003, 4'h0, 1, 0, 1, "R7");
    step(1, 0, 32'h7000_0004, 4'h0, 0, 0, 1, "R7");
    step(1, 0, 32'h7000_0005, 4'h0, 0, 0, 1, "R7");
    idle(5, "R7");
    set_lat(3'b010);
    idle(2, "R7");
    step(1, 1, 32'h8000_0001, 4'h0, 0, 0, 1, "R7");
    step(1, 0, 32'h8000_0002, 4'h0, 0, 1, 1, "R7");
    step(1, 0, 32'h8000_0003, 4'h0, 0, 0, 1, "R7");
    idle(4, "R7");
  endtask

  // R8: clock enable low holds everything for the following edges
  task automatic t_freeze();
    set_lat(3'b011);
    idle(2, "R8");
    step(1, 1, 32'h9000_0001, 4'h0, 0, 0, 1, "R8");
    step(1, 0, 32'h9000_0002, 4'h0, 0, 0, 0, "R8");
    step(1, 0, 32'h9000_00FF, 4'b1111, 0, 0, 0, "R8");
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R8");
    step(1, 0, 32'h9000_0003, 4'h0, 0, 0, 1, "R8");
    step(0, 0, 32'h0, 4'h0, 0, 0, 0, "R8");
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R8");
    idle(5, "R8");
  endtask

  // R9, R11: code change while busy flags once; change while idle does not
  task automatic t_err();
    set_lat(3'b011);
    idle(2, "R9");
    cmp_dq = 1'b0;
    step(1, 1, 32'hDEAD_0001, 4'h0, 0, 0, 1, "R9");
    set_lat(3'b010);
    exp_err = 1'b1;
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R9");
    exp_err = 1'b0;
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R9");
    idle(4, "R9");
    set_lat(3'b011);
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R11");
    set_lat(3'b010);
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R11");
    idle(2, "R11");
    cmp_dq = 1'b1;
  endtask

  // R10: reserved codes flag on every edge they are present
  task automatic t_reserved();
    lat_code = 3'b101;
    exp_err  = 1'b1;
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R10");
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R10");
    lat_code = 3'b000;
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R10");
    set_lat(3'b011);
    exp_err = 1'b0;
    step(0, 0, 32'h0, 4'h0, 0, 0, 1, "R10");
    idle(2, "R10");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    for (int i = 0; i < SLOTS; i++) begin
      exp_vld[i] = 1'b0; exp_data[i] = '0; msk_at[i] = '0;
    end
    pe = 0; adv_next = 1'b1; live_m = 1'b0; cmp_dq = 1'b1; exp_err = 1'b0;
    rst_n = 1'b0; clk_en = 1'b1; set_lat(3'b010);
    rd_start = 0; beat_vld = 0; beat_data = '0; byte_mask = '0;
    burst_stop = 0; pre_cmd = 0;
    repeat (3) @(negedge clk);
    check("R1", "dq_oe", 64'(dq_oe), 64'h0);
    check("R1", "dq_out", 64'(dq_out), 64'h0);
    check("R1", "lat_err", 64'(lat_err), 64'h0);
    rst_n = 1'b1;
    idle(4, "R1");
    t_cl2_basic();
    t_cl3_basic();
    t_stray();
    t_mask(3'b010);
    t_mask(3'b011);
    t_term();
    t_freeze();
    t_err();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule